// File: doc/BRIEF.md
# Serial Frame Transmitter with Queue

This block turns bytes pushed by a host into asynchronous serial frames on a single output line. Each write goes into a small queue. When transmission is allowed and the queue has an entry, the shift engine takes the oldest byte and sends it. The frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

Each bit lasts a fixed number of pulses of an external oversampling tick, either 16 or 8. The receiving side of a link uses the same tick, and the same control codes select the frame shape on both sides. The frame settings are captured when a frame starts, so a change in the middle of a frame affects only later frames.

One interrupt output is formed from four sources, and each source has its own mask bit. The sources are: the queue reaching a programmable fill level, a write dropped because the queue was full, nothing left to send, and a change on the clear-to-send input. Two status outputs tell the host whether it may write and whether a frame is on the line.

Top module: `serial_tx_fifo`

## Requirements
- R1: A frame is one low start bit, then the data bits least significant first, then the stop bits, which are high. `txd` is high whenever no frame is being sent.
- R2: `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits above the selected size are not sent.
- R3: When `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_even`=1 it makes the count of ones in data plus parity even. With `cfg_par_even`=0 it makes that count odd.
- R4: `cfg_stop2`=1 sends two stop bits. `cfg_stop2`=0 sends one.
- R5: Each bit lasts 16 `tick` pulses when `cfg_ovs8`=0 and 8 pulses when `cfg_ovs8`=1.
- R6: No frame starts while `cfg_enable`=0. Written data stays queued and `txd` stays high.
- R7: A write while the queue holds `DEPTH` entries is dropped and the fill count does not change. It sets an overflow flag that stays set until `status_clear`. That flag is interrupt source bit 1.
- R8: Interrupt source bit 0 is active while the fill count is greater than or equal to `level_trig`.
- R9: Interrupt source bit 2 is active only when the queue is empty and no frame is in progress.
- R10: A `fifo_clear` pulse empties the queue. Entries removed this way are never sent.
- R11: `wr_ready` is 1 exactly when the queue has room. `busy` is 1 from the start bit through the last stop bit.
- R12: Any change of `cts_n` sets a flag that stays set until `status_clear`. That flag is interrupt source bit 3. `irq` is the registered OR of the sources whose bit in `irq_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Oversampling tick, one-cycle pulse |
| cfg_enable | input | 1 | Allow new frames to start |
| cfg_wlen | input | 2 | Data size code: 0..3 selects 5..8 bits |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_even | input | 1 | 1 for even parity, 0 for odd |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_ovs8 | input | 1 | 8 ticks per bit instead of 16 |
| wr_valid | input | 1 | Write strobe for one entry |
| wr_data | input | 8 | Byte to queue |
| fifo_clear | input | 1 | Empty the queue |
| status_clear | input | 1 | Clear the overflow and line-change flags |
| level_trig | input | CW | Fill level that activates source bit 0 |
| irq_mask | input | 4 | Enable per source: 0 level, 1 overflow, 2 empty, 3 line change |
| cts_n | input | 1 | Clear-to-send line, monitored for changes |
| txd | output | 1 | Serial output |
| wr_ready | output | 1 | Queue has room |
| busy | output | 1 | Frame in progress |
| fifo_count | output | CW | Entries in the queue |
| irq | output | 1 | Combined masked interrupt |

## Verification
Frames are decoded at the line by sampling the middle of each bit. The patterns are chosen so that a swapped bit order, a wrong size mask or an inverted parity sense each give a different decoded value. Each data size code is tried with a byte whose upper bits are set, so sending too many bits shows up as a stop bit read as zero. Back-to-back frames are sent with two stop bits and again with 8x oversampling, and the time between start edges is measured; this tells apart a missing stop bit and a wrong tick count per bit. The queue is filled while sending is disabled, overflowed and flushed, to separate the level, overflow, empty-while-busy and line-change interrupt sources, each behind its own mask.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int DATA_W  = 8;
  localparam int OVS_HI  = 16;
  localparam int OVS_LO  = 8;
  localparam int TCW     = $clog2(OVS_HI);
  localparam int NSRC    = 4;
  localparam int SRC_LEVEL = 0;
  localparam int SRC_OVF   = 1;
  localparam int SRC_EMPTY = 2;
  localparam int SRC_CTS   = 3;

  typedef enum logic [2:0] {
    SH_IDLE, SH_START, SH_DATA, SH_PARITY, SH_STOP
  } sh_state_t;

  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] code);
    return {DATA_W{1'b1}} >> (2'd3 - code);
  endfunction
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf_pulse
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign push      = wr_en && !full && !clr;
  assign pop       = rd_en && !empty && !clr;
  assign ovf_pulse = wr_en && full && !clr;
  assign rd_data   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)) else $error("queue count above depth"); // R7
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> count <= $past(count)) else $error("write accepted while full"); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0) else $error("clear left entries"); // R10
endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
  import tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              enable,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              stop2,
  input  logic              ovs8,
  input  logic              avail,
  input  logic [DATA_W-1:0] data,
  output logic              take,
  output logic              txd,
  output logic              busy
);
  sh_state_t         state;
  logic [DATA_W-1:0] shreg;
  logic [2:0]        bit_idx;
  logic [2:0]        last_idx;
  logic [TCW-1:0]    tick_cnt;
  logic              stop_idx;
  logic              par_q, pen_q, stop2_q, ovs8_q;
  logic              bit_end;
  logic [DATA_W-1:0] masked;

  assign masked  = data & size_mask(wlen);
  assign take    = (state == SH_IDLE) && enable && avail;
  assign busy    = (state != SH_IDLE);
  assign bit_end = tick && (tick_cnt == (ovs8_q ? TCW'(OVS_LO - 1) : TCW'(OVS_HI - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SH_IDLE;
      txd      <= 1'b1;
      shreg    <= '0;
      bit_idx  <= '0;
      last_idx <= '0;
      tick_cnt <= '0;
      stop_idx <= 1'b0;
      par_q    <= 1'b0;
      pen_q    <= 1'b0;
      stop2_q  <= 1'b0;
      ovs8_q   <= 1'b0;
    end else if (state == SH_IDLE) begin
      txd <= 1'b1;
      if (take) begin
        state    <= SH_START;
        txd      <= 1'b0;
        shreg    <= masked;
        par_q    <= par_even ? ^masked : ~^masked;
        last_idx <= 3'(wlen) + 3'd4;
        pen_q    <= par_en;
        stop2_q  <= stop2;
        ovs8_q   <= ovs8;
        bit_idx  <= '0;
        stop_idx <= 1'b0;
        tick_cnt <= '0;
      end
    end else if (tick) begin
      if (!bit_end) begin
        tick_cnt <= tick_cnt + TCW'(1);
      end else begin
        tick_cnt <= '0;
        case (state)
          SH_START: begin
            state <= SH_DATA;
            txd   <= shreg[0];
            shreg <= shreg >> 1;
          end
          SH_DATA: begin
            if (bit_idx == last_idx) begin
              if (pen_q) begin
                state <= SH_PARITY;
                txd   <= par_q;
              end else begin
                state <= SH_STOP;
                txd   <= 1'b1;
              end
            end else begin
              bit_idx <= bit_idx + 3'd1;
              txd     <= shreg[0];
              shreg   <= shreg >> 1;
            end
          end
          SH_PARITY: begin
            state <= SH_STOP;
            txd   <= 1'b1;
          end
          SH_STOP: begin
            if (stop2_q && !stop_idx) begin
              stop_idx <= 1'b1;
            end else begin
              state <= SH_IDLE;
              txd   <= 1'b1;
            end
          end
          default: begin
            state <= SH_IDLE;
            txd   <= 1'b1;
          end
        endcase
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd) else $error("line low while idle"); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd) else $error("frame began without start bit"); // R1
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!busy && !enable) |=> !busy) else $error("frame began while disabled"); // R6
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == SH_STOP) |-> txd) else $error("stop bit low"); // R4
endmodule

// File: rtl/txq_irq.sv
module txq_irq
  import tx_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   count,
  input  logic [CW-1:0]   level_trig,
  input  logic            ovf_pulse,
  input  logic            fifo_empty,
  input  logic            busy,
  input  logic            cts_n,
  input  logic            status_clear,
  input  logic [NSRC-1:0] mask,
  output logic            irq
);
  logic            ovf_q, cts_q;
  logic [2:0]      cts_sync;
  logic            cts_change;
  logic [NSRC-1:0] src;

  assign cts_change = cts_sync[1] ^ cts_sync[2];

  always_comb begin
    src            = '0;
    src[SRC_LEVEL] = (count >= level_trig);
    src[SRC_OVF]   = ovf_q;
    src[SRC_EMPTY] = fifo_empty && !busy;
    src[SRC_CTS]   = cts_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q    <= 1'b0;
      cts_q    <= 1'b0;
      cts_sync <= 3'b111;
      irq      <= 1'b0;
    end else begin
      cts_sync <= {cts_sync[1:0], cts_n};
      if (ovf_pulse)         ovf_q <= 1'b1;
      else if (status_clear) ovf_q <= 1'b0;
      if (cts_change)        cts_q <= 1'b1;
      else if (status_clear) cts_q <= 1'b0;
      irq <= |(src & mask);
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !status_clear) |=> ovf_q) else $error("overflow flag lost"); // R7
  AST_CTS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cts_q && !status_clear) |=> cts_q) else $error("line-change flag lost"); // R12
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !irq) else $error("irq with all sources masked"); // R12
endmodule

// File: rtl/serial_tx_fifo.sv
module serial_tx_fifo
  import tx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_stop2,
  input  logic              cfg_ovs8,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fifo_clear,
  input  logic              status_clear,
  input  logic [CW-1:0]     level_trig,
  input  logic [NSRC-1:0]   irq_mask,
  input  logic              cts_n,
  output logic              txd,
  output logic              wr_ready,
  output logic              busy,
  output logic [CW-1:0]     fifo_count,
  output logic              irq
);
  logic [DATA_W-1:0] q_data;
  logic              q_full, q_empty, q_ovf, take;

  txq_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clear),
    .wr_en(wr_valid), .wr_data(wr_data),
    .rd_en(take), .rd_data(q_data),
    .count(fifo_count), .full(q_full), .empty(q_empty), .ovf_pulse(q_ovf)
  );

  txq_shifter u_shift (
    .clk(clk), .rst(rst), .tick(tick), .enable(cfg_enable),
    .wlen(cfg_wlen), .par_en(cfg_par_en), .par_even(cfg_par_even),
    .stop2(cfg_stop2), .ovs8(cfg_ovs8),
    .avail(!q_empty && !fifo_clear), .data(q_data),
    .take(take), .txd(txd), .busy(busy)
  );

  txq_irq #(.CW(CW)) u_irq (
    .clk(clk), .rst(rst), .count(fifo_count), .level_trig(level_trig),
    .ovf_pulse(q_ovf), .fifo_empty(q_empty), .busy(busy), .cts_n(cts_n),
    .status_clear(status_clear), .mask(irq_mask), .irq(irq)
  );

  assign wr_ready = !q_full;

  AST_READY_MATCHES: assert property (@(posedge clk) disable iff (rst)
    wr_ready == (fifo_count < CW'(DEPTH))) else $error("ready disagrees with count"); // R11
endmodule

// File: tb/sim_serial_tx_fifo.sv
module sim_serial_tx_fifo;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int TDIV  = 4;

  logic clk = 0, rst = 1, tick = 0;
  logic cfg_enable = 0, cfg_par_en = 0, cfg_par_even = 0, cfg_stop2 = 0, cfg_ovs8 = 0;
  logic [1:0] cfg_wlen = 2'd3;
  logic wr_valid = 0, fifo_clear = 0, status_clear = 0, cts_n = 1;
  logic [7:0] wr_data = 0;
  logic [CW-1:0] level_trig = '1;
  logic [3:0] irq_mask = 0;
  logic txd, wr_ready, busy, irq;
  logic [CW-1:0] fifo_count;

  int checks = 0, failures = 0, div = 0;
  longint cyc = 0;
  bit done = 0;
  logic [7:0] rx_d;
  bit rx_p, rx_ok;
  longint rx_t;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    tick <= (div == TDIV - 1);
    div  <= (div == TDIV - 1) ? 0 : div + 1;
  end

  serial_tx_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .cfg_enable(cfg_enable), .cfg_wlen(cfg_wlen),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .cfg_stop2(cfg_stop2),
    .cfg_ovs8(cfg_ovs8), .wr_valid(wr_valid), .wr_data(wr_data),
    .fifo_clear(fifo_clear), .status_clear(status_clear), .level_trig(level_trig),
    .irq_mask(irq_mask), .cts_n(cts_n), .txd(txd), .wr_ready(wr_ready),
    .busy(busy), .fifo_count(fifo_count), .irq(irq)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d);
    wr_data = d; wr_valid = 1;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic pulse_status;
    status_clear = 1; @(negedge clk); status_clear = 0;
  endtask

  // decode one frame by sampling the middle of each bit
  task automatic rx_frame(input int nbits, input bit pen, input int nst, input int tpb);
    int bitc = tpb * TDIV;
    int guard = 0;
    rx_d = 0; rx_ok = 1; rx_p = 0;
    while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    if (guard >= 5000) begin
      check("R1 start bit seen", 0, 1);
      rx_ok = 0;
      return;
    end
    rx_t = cyc;
    wait_clk(bitc / 2);
    if (txd !== 1'b0) rx_ok = 0;
    for (int i = 0; i < nbits; i++) begin
      wait_clk(bitc);
      rx_d[i] = txd;
    end
    if (pen) begin wait_clk(bitc); rx_p = txd; end
    for (int s = 0; s < nst; s++) begin
      wait_clk(bitc);
      if (txd !== 1'b1) rx_ok = 0;
    end
  endtask

  task automatic t_reset;
    check("R1 reset txd", txd, 1);
    check("R11 reset ready", wr_ready, 1);
    check("R11 reset busy", busy, 0);
    check("R10 reset count", fifo_count, 0);
    check("R12 reset irq", irq, 0);
  endtask

  task automatic t_basic;
    cfg_enable = 1; cfg_wlen = 3; cfg_par_en = 0; cfg_stop2 = 0; cfg_ovs8 = 0;
    put(8'hA5);
    wait_clk(3);
    check("R11 busy during frame", busy, 1);
    rx_frame(8, 0, 1, 16);
    check("R1 data lsb first", rx_d, 8'hA5);
    check("R1 framing bits", rx_ok, 1);
    put(8'h3C);
    rx_frame(8, 0, 1, 16);
    check("R1 second pattern", rx_d, 8'h3C);
    wait_clk(80);
    check("R11 busy clear after frame", busy, 0);
  endtask

  task automatic t_wlen;
    for (int wl = 0; wl < 3; wl++) begin
      cfg_wlen = 2'(wl);
      put(8'hF6);
      rx_frame(5 + wl, 0, 1, 16);
      check("R2 masked data", rx_d, 8'hF6 & (8'hFF >> (3 - wl)));
      check("R2 stop after size", rx_ok, 1);
      wait_clk(80);
    end
    cfg_wlen = 3;
  endtask

  task automatic t_parity;
    cfg_par_en = 1;
    cfg_par_even = 1; put(8'h07); rx_frame(8, 1, 1, 16);
    check("R3 even parity of 0x07", rx_p, 1);
    check("R3 data", rx_d, 8'h07);
    wait_clk(80);
    cfg_par_even = 0; put(8'h07); rx_frame(8, 1, 1, 16);
    check("R3 odd parity of 0x07", rx_p, 0);
    wait_clk(80);
    cfg_par_even = 1; put(8'h03); rx_frame(8, 1, 1, 16);
    check("R3 even parity of 0x03", rx_p, 0);
    check("R3 stop after parity", rx_ok, 1);
    wait_clk(80);
    cfg_par_en = 0;
  endtask

  task automatic t_timing;
    longint t0;
    cfg_stop2 = 1;
    put(8'h55); put(8'hAA);
    rx_frame(8, 0, 2, 16); t0 = rx_t;
    check("R4 first data", rx_d, 8'h55);
    check("R4 both stops high", rx_ok, 1);
    rx_frame(8, 0, 2, 16);
    check("R4 second data", rx_d, 8'hAA);
    check("R4 period two stops", ((rx_t - t0) > 700 && (rx_t - t0) < 708), 1);
    wait_clk(150);
    cfg_stop2 = 0; cfg_ovs8 = 1;
    put(8'h81); put(8'h18);
    rx_frame(8, 0, 1, 8); t0 = rx_t;
    check("R5 data at 8x", rx_d, 8'h81);
    rx_frame(8, 0, 1, 8);
    check("R5 second data at 8x", rx_d, 8'h18);
    check("R5 period 8x", ((rx_t - t0) > 316 && (rx_t - t0) < 324), 1);
    wait_clk(80);
    cfg_ovs8 = 0;
  endtask

  task automatic t_fill;
    bit line_low = 0;
    cfg_enable = 0;
    pulse_status;
    for (int i = 0; i < DEPTH; i++) begin
      put(8'(i + 1));
      if (txd !== 1'b1) line_low = 1;
    end
    wait_clk(100);
    if (txd !== 1'b1 || busy) line_low = 1;
    check("R6 line high while disabled", line_low, 0);
    check("R6 data held", fifo_count, DEPTH);
    check("R11 not ready when full", wr_ready, 0);
    irq_mask = 4'b0010;
    wait_clk(3);
    check("R7 no overflow yet", irq, 0);
    put(8'hEE);
    check("R7 count unchanged", fifo_count, DEPTH);
    wait_clk(3);
    check("R7 overflow irq", irq, 1);
    wait_clk(10);
    check("R7 overflow sticky", irq, 1);
    pulse_status;
    wait_clk(3);
    check("R7 status clear", irq, 0);
  endtask

  task automatic t_level;
    irq_mask = 4'b0001;
    level_trig = CW'(DEPTH);
    wait_clk(3);
    check("R8 count at trigger", irq, 1);
    level_trig = CW'(DEPTH + 1);
    wait_clk(3);
    check("R8 count below trigger", irq, 0);
    level_trig = CW'(3);
    wait_clk(3);
    check("R8 count above trigger", irq, 1);
    level_trig = '1;
  endtask

  task automatic t_clear;
    bit line_low = 0;
    irq_mask = 0;
    fifo_clear = 1; @(negedge clk); fifo_clear = 0;
    check("R10 count after clear", fifo_count, 0);
    check("R10 ready after clear", wr_ready, 1);
    cfg_enable = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || busy) line_low = 1;
    end
    check("R10 flushed data not sent", line_low, 0);
  endtask

  task automatic t_empty;
    irq_mask = 4'b0100;
    wait_clk(3);
    check("R9 empty and idle", irq, 1);
    put(8'h42);
    wait_clk(10);
    check("R9 queue empty but busy", irq, 0);
    check("R11 busy", busy, 1);
    rx_frame(8, 0, 1, 16);
    check("R9 frame data", rx_d, 8'h42);
    wait_clk(80);
    check("R9 empty after frame", irq, 1);
    irq_mask = 0;
  endtask

  task automatic t_cts;
    irq_mask = 0;
    pulse_status;
    cts_n = 0; wait_clk(6);
    check("R12 masked change quiet", irq, 0);
    irq_mask = 4'b1000;
    wait_clk(3);
    check("R12 unmasked sticky change", irq, 1);
    pulse_status; wait_clk(3);
    check("R12 cleared", irq, 0);
    cts_n = 1; wait_clk(6);
    check("R12 rising change", irq, 1);
    pulse_status; wait_clk(3);
    check("R12 cleared again", irq, 0);
    irq_mask = 0;
  endtask

  initial begin
    wait_clk(5);
    rst = 0;
    wait_clk(2);
    t_reset;
    t_basic;
    t_wlen;
    t_parity;
    t_timing;
    t_fill;
    t_level;
    t_clear;
    t_empty;
    t_cts;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule